// File: doc/BRIEF.md
# Strobe Transfer Across Unrelated Clocks

This block moves one-cycle strobes from a source clock domain into a destination clock domain that has no phase or frequency relation to it. Every strobe that the block accepts comes out as exactly one destination-cycle pulse; none is lost or doubled. A level copied through a plain two-flop synchronizer cannot give that guarantee for strobes: a short pulse can fall between destination edges, and a long one can be seen twice.

Each lane turns an accepted strobe into a flip of a source-side level bit. That bit goes through a chain of destination flops, and a change detector at the far end turns every flip (either polarity) back into one registered pulse. The level seen in the destination is carried back through a second chain of source flops; where the local bit and the returned copy differ, a transfer is still in progress and the lane's busy flag is high. A build-time option makes a lane drop new strobes while its busy flag is high, so that two flips can never cancel in flight. Lanes are fully independent.

Top module: `pulse_strobe_bridge`

## Requirements
- R1: After reset (both resets held high for at least one edge of their clock) every busy flag and every destination pulse is 0, and both stay 0 while no strobe is presented.
- R2: A transfer starts only on a 0-to-1 change of a lane's strobe input between two successive source clock edges; holding the strobe high for many cycles produces one destination pulse.
- R3: Every accepted strobe produces exactly one destination pulse, one destination cycle wide; per lane, the count of pulses equals the count of accepted strobes.
- R4: For an isolated strobe, the destination pulse is visible between SYNC_STAGES and SYNC_STAGES+3 destination clock cycles after the source edge that accepts it.
- R5: A lane's busy flag is 1 in the source cycle after an accepted strobe and returns to 0 once the destination has taken the change, within a bounded number of cycles.
- R6: With GATE_BUSY=1, a rising strobe that meets a high busy flag is dropped: it yields no pulse, and two destination pulses of one lane are never on adjacent destination cycles.
- R7: With GATE_BUSY=0, a rising strobe is always accepted, so a second strobe during busy flips the lane level back and the busy flag falls before the round trip completes.
- R8: Lanes do not interact: strobes on one lane change neither the busy flag nor the pulse count of another lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst | input | 1 | Synchronous active-high reset, source domain |
| src_strobe | input | LANES | Per-lane strobe inputs, source domain |
| src_busy | output | LANES | Per-lane transfer-in-progress flags, source domain |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst | input | 1 | Synchronous active-high reset, destination domain |
| dst_pulse | output | LANES | Per-lane registered one-cycle pulses, destination domain |

## Verification
A corrupted lane level shows up as a pulse with no strobe behind it, or a missing pulse, a few destination cycles after the fault, so per-lane pulse counts compared against a model driven by the observed busy flag expose it at the next quiet point. A broken return path shows as a busy flag that never falls or falls too early, which the gated and ungated instances reveal within one round trip. Running the same traffic with the destination clock both faster and slower than the source clock brings out missed and doubled pulses that only one frequency ratio would hide.

// File: rtl/sx_pkg.sv
`timescale 1ns/1ps
package sx_pkg;
  localparam int unsigned SX_MIN_STAGES = 2;

  function automatic int unsigned sx_stages(input int unsigned req);
    return (req < SX_MIN_STAGES) ? SX_MIN_STAGES : req;
  endfunction
endpackage

// File: rtl/sx_sync_chain.sv
`timescale 1ns/1ps
// Multi-flop level synchronizer, one chain per bit of the vector.
module sx_sync_chain #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/sx_src_side.sv
`timescale 1ns/1ps
// Source domain: edge detect, toggle level, busy from returned level.
module sx_src_side #(
  parameter int unsigned LANES = 1,
  parameter bit          GATE  = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] strobe,
  input  logic [LANES-1:0] ret_level,
  output logic [LANES-1:0] level,
  output logic [LANES-1:0] busy
);
  logic [LANES-1:0] prev_q;
  logic [LANES-1:0] tog_q;
  logic [LANES-1:0] rise;
  logic [LANES-1:0] accept;

  assign rise = strobe & ~prev_q;
  assign busy = tog_q ^ ret_level;

  if (GATE) begin : g_gated
    assign accept = rise & ~busy;
  end else begin : g_open
    assign accept = rise;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      tog_q  <= '0;
    end else begin
      prev_q <= strobe;
      tog_q  <= tog_q ^ accept;
    end
  end

  assign level = tog_q;

  for (genvar i = 0; i < LANES; i++) begin : g_chk
    p_reset_idle_r1: assert property (@(posedge clk) rst |=> !busy[i]);
    if (GATE) begin : g_gchk
      p_busy_after_accept_r5: assert property (@(posedge clk) disable iff (rst)
        accept[i] |=> busy[i]);
      p_drop_when_busy_r6: assert property (@(posedge clk) disable iff (rst)
        (rise[i] && busy[i]) |=> $stable(tog_q[i]));
    end else begin : g_ochk
      p_always_flip_r7: assert property (@(posedge clk) disable iff (rst)
        rise[i] |=> (tog_q[i] != $past(tog_q[i])));
    end
  end
endmodule

// File: rtl/sx_dst_side.sv
`timescale 1ns/1ps
// Destination domain: level change detector with registered pulse.
module sx_dst_side #(
  parameter int unsigned LANES = 1,
  parameter bit          GATE  = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] sync_level,
  output logic [LANES-1:0] pulse
);
  logic [LANES-1:0] prev_q;
  logic [LANES-1:0] pulse_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= '0;
      pulse_q <= '0;
    end else begin
      prev_q  <= sync_level;
      pulse_q <= sync_level ^ prev_q;
    end
  end

  assign pulse = pulse_q;

  for (genvar i = 0; i < LANES; i++) begin : g_chk
    p_reset_quiet_r1: assert property (@(posedge clk) rst |=> !pulse[i]);
    if (GATE) begin : g_gchk
      p_no_adjacent_r6: assert property (@(posedge clk) disable iff (rst)
        pulse[i] |=> !pulse[i]);
    end
  end
endmodule

// File: rtl/pulse_strobe_bridge.sv
`timescale 1ns/1ps
module pulse_strobe_bridge
  import sx_pkg::*;
#(
  parameter int unsigned LANES       = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          GATE_BUSY   = 1'b1
) (
  input  logic             src_clk,
  input  logic             src_rst,
  input  logic [LANES-1:0] src_strobe,
  output logic [LANES-1:0] src_busy,
  input  logic             dst_clk,
  input  logic             dst_rst,
  output logic [LANES-1:0] dst_pulse
);
  localparam int unsigned EFF_STAGES = sx_stages(SYNC_STAGES);

  logic [LANES-1:0] src_level;
  logic [LANES-1:0] dst_level;
  logic [LANES-1:0] ret_level;

  sx_src_side #(.LANES(LANES), .GATE(GATE_BUSY)) u_src (
    .clk(src_clk), .rst(src_rst), .strobe(src_strobe),
    .ret_level(ret_level), .level(src_level), .busy(src_busy)
  );

  sx_sync_chain #(.WIDTH(LANES), .STAGES(EFF_STAGES)) u_fwd (
    .clk(dst_clk), .rst(dst_rst), .d(src_level), .q(dst_level)
  );

  sx_dst_side #(.LANES(LANES), .GATE(GATE_BUSY)) u_dst (
    .clk(dst_clk), .rst(dst_rst), .sync_level(dst_level), .pulse(dst_pulse)
  );

  sx_sync_chain #(.WIDTH(LANES), .STAGES(EFF_STAGES)) u_ret (
    .clk(src_clk), .rst(src_rst), .d(dst_level), .q(ret_level)
  );
endmodule

// File: tb/pulse_strobe_bridge_tb_top.sv
`timescale 1ns/1ps
module pulse_strobe_bridge_tb_top;
  localparam int L  = 4;
  localparam int ST = 2;

  logic src_clk = 1'b0, dst_clk = 1'b0;
  logic src_rst = 1'b1, dst_rst = 1'b1;
  logic [L-1:0] strobe = '0;
  logic [L-1:0] busy_g, busy_o, pulse_g, pulse_o;
  real  dst_half = 3.1;

  int checks = 0, errors = 0;
  int exp_cnt [L];
  int got_cnt [L];
  logic [L-1:0] prev_s = '0;
  logic [L-1:0] last_p = '0;
  int adjacent = 0;
  bit done = 1'b0;

  always #2 src_clk = ~src_clk;
  always #(dst_half) dst_clk = ~dst_clk;

  pulse_strobe_bridge #(.LANES(L), .SYNC_STAGES(ST), .GATE_BUSY(1'b1)) dut_i (
    .src_clk(src_clk), .src_rst(src_rst), .src_strobe(strobe), .src_busy(busy_g),
    .dst_clk(dst_clk), .dst_rst(dst_rst), .dst_pulse(pulse_g));

  pulse_strobe_bridge #(.LANES(L), .SYNC_STAGES(ST), .GATE_BUSY(1'b0)) dut_ng_i (
    .src_clk(src_clk), .src_rst(src_rst), .src_strobe(strobe), .src_busy(busy_o),
    .dst_clk(dst_clk), .dst_rst(dst_rst), .dst_pulse(pulse_o));

  always @(negedge dst_clk) begin
    if (!dst_rst) begin
      for (int i = 0; i < L; i++) begin
        if (pulse_g[i]) got_cnt[i]++;
        if (pulse_g[i] && last_p[i]) adjacent++;
      end
      last_p = pulse_g;
    end
  end

  function automatic bit accepted(logic s, logic p, logic b);
    return s && !p && !b;
  endfunction

  task automatic chk(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic step(logic [L-1:0] s);
    @(negedge src_clk);
    for (int i = 0; i < L; i++)
      if (accepted(s[i], prev_s[i], busy_g[i])) exp_cnt[i]++;
    prev_s = s;
    strobe = s;
  endtask

  task automatic settle(string tag);
    int n = 0;
    step('0);
    while (busy_g != '0 && n < 200) begin
      step('0);
      n++;
    end
    chk(busy_g == '0, tag, int'(busy_g), 0);
    repeat (12) @(negedge dst_clk);
  endtask

  task automatic compare_counts(string tag);
    for (int i = 0; i < L; i++)
      chk(got_cnt[i] == exp_cnt[i], tag, got_cnt[i], exp_cnt[i]);
  endtask

  task automatic random_run(int n);
    for (int k = 0; k < n; k++) begin
      logic [L-1:0] s;
      for (int i = 0; i < L; i++) s[i] = ($urandom % 3) == 0;
      step(s);
    end
  endtask

  initial begin
    int base, lat, seed_dummy;
    seed_dummy = $urandom(32'h5eed_1234);
    for (int i = 0; i < L; i++) begin exp_cnt[i] = 0; got_cnt[i] = 0; end
    repeat (4) @(posedge dst_clk);
    @(negedge src_clk) src_rst = 1'b0;
    @(negedge dst_clk) dst_rst = 1'b0;

    // R1: quiet after reset
    for (int k = 0; k < 6; k++) begin
      step('0);
      chk(busy_g == '0 && busy_o == '0, "R1 busy idle", int'(busy_g), 0);
      chk(pulse_g == '0, "R1 pulse idle", int'(pulse_g), 0);
    end

    // R4 latency, R5 busy rise, R8 other lanes untouched
    step(4'b0001);
    @(posedge src_clk);
    lat = 0;
    while (lat < 20) begin
      @(negedge dst_clk);
      lat++;
      if (pulse_g[0]) break;
    end
    chk(lat >= ST && lat <= ST + 3, "R4 pulse latency", lat, ST + 2);
    settle("R5 busy clears lane0");
    step(4'b0010);
    step(4'b0000);
    chk(busy_g[1] == 1'b1, "R5 busy after accept", int'(busy_g[1]), 1);
    chk(busy_g[3:2] == 2'b00 && busy_g[0] == 1'b0, "R8 other lanes idle", int'(busy_g), 2);
    settle("R5 busy clears lane1");
    compare_counts("R3 counts after single strobes");
    chk(got_cnt[3] == 0, "R8 untouched lane count", got_cnt[3], 0);

    // R2: held high gives one transfer
    base = got_cnt[1];
    for (int k = 0; k < 40; k++) step(4'b0010);
    settle("R5 busy clears after hold");
    chk(got_cnt[1] - base == 1, "R2 held strobe one pulse", got_cnt[1] - base, 1);

    // R6 gated drop, R7 ungated flip-back
    base = got_cnt[2];
    step(4'b0100);
    step(4'b0000);
    step(4'b0100);
    step(4'b0000);
    chk(busy_g[2] == 1'b1, "R6 gated busy held", int'(busy_g[2]), 1);
    chk(busy_o[2] == 1'b0, "R7 ungated flip back", int'(busy_o[2]), 0);
    settle("R5 busy clears after drop");
    chk(got_cnt[2] - base == 1, "R6 dropped strobe no pulse", got_cnt[2] - base, 1);

    // Random traffic, three clock ratios
    random_run(3000);
    settle("R5 busy clears phase A");
    compare_counts("R3 counts dst slower");
    dst_half = 1.3;
    random_run(3000);
    settle("R5 busy clears phase B");
    compare_counts("R3 counts dst faster");
    dst_half = 9.0;
    random_run(2000);
    settle("R5 busy clears phase C");
    compare_counts("R3 counts dst much slower");
    chk(adjacent == 0, "R6 no adjacent pulses", adjacent, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge src_clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule